// File: doc/BRIEF.md
# Sequential Flash Instruction Prefetcher

This block sits between a processor's instruction fetch port and a slow flash read port whose access takes a configurable number of wait states. Once prefetching is switched on and a fetch has been served, the block reads the next sequential word from flash before the processor asks for it. The word is held in a single-entry buffer that stores its address and a valid flag. If the next fetch is for that word, the block answers it from the buffer in the same cycle. If the fetch is for some other address, the speculative read is allowed to finish, its data is thrown away, and the requested word is then read.

Prefetching is off after reset. In that state every fetch goes to flash and pays the full wait-state cost. A flush input lets the surrounding logic clear the buffer. It is meant to be pulsed on a taken branch, or whenever the enable or the wait-state setting is changed.

Latencies below are counted in clock edges: from the cycle in which `fetch_req` is first raised to the cycle in which `fetch_ready` is high. Addresses are byte addresses, and a word is 4 bytes.

Top module: `flash_prefetcher`

## Requirements
- R1: After reset, `fetch_ready` and `flash_rd` are low, and no flash read starts while there is no fetch request and prefetching is off.
- R2: Each flash read holds `flash_rd` high for exactly `wait_states`+1 consecutive cycles, with `flash_addr` word-aligned and unchanged for the whole read.
- R3: A fetch that misses while the flash port is idle gets `fetch_ready` after `wait_states`+2 edges. `fetch_data` then equals the flash word at the fetch address, with `fetch_addr[1:0]` ignored.
- R4: With `pf_en` low, fetching the same address twice still costs `wait_states`+2 edges each time, and no flash read starts after a fetch is served.
- R5: With `pf_en` high, in the cycle after a fetch is served from an idle flash port, a read of the next word (address + 4) is in progress.
- R6: With `pf_en` high, a fetch of address+4 raised in the cycle right after address was served becomes ready after `wait_states`+1 edges.
- R7: With `pf_en` high, a fetch of the next word raised after the speculative read has finished is ready in the same cycle (0 edges).
- R8: A fetch that does not match the speculative read in flight waits for that read to end, discards its data, then reads the requested word: `fetch_ready` comes 2×`wait_states`+3 edges after a request raised one cycle after the previous fetch was served.
- R9: A one-cycle `flush` pulse invalidates the buffer. A later fetch of the word that was prefetched then costs the full `wait_states`+2 edges, and `fetch_ready` is low in the cycle after any flush.
- R10: The next-word address wraps modulo 2^`ADDR_W`, so a fetch of the last word is followed by a prefetch of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_en | input | 1 | Prefetch enable |
| wait_states | input | WS_W | Flash wait states; each read lasts this value plus one cycle |
| flush | input | 1 | Invalidates the buffer and any read in flight |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | DATA_W | Instruction word, valid with `fetch_ready` |
| flash_rd | output | 1 | Flash read in progress |
| flash_addr | output | ADDR_W | Word-aligned flash read address |
| flash_rdata | input | DATA_W | Flash data for `flash_addr`, sampled in the last read cycle |

## Verification
The bench builds the block with `ADDR_W`=12, `DATA_W`=32 and `WS_W`=4. The 12-bit address space puts the wrap from the top word (0xFFC) back to 0 within reach of a short directed test. The wait-state input is driven at 3 for most scenarios, which separates the latencies of a miss, a back-to-back prefetch hit and a mismatch discard. It is also driven at 0 to cover a single-cycle flash read.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Purpose of the flash read currently owned by the engine
  typedef enum logic [1:0] {
    RK_IDLE   = 2'd0,
    RK_DEMAND = 2'd1,
    RK_SPEC   = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/pf_rd_engine.sv
module pf_rd_engine
  import pf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rd_kind_e          start_kind,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WS_W-1:0]   ws,
  input  logic              flush,
  output logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  output rd_kind_e          kind,
  output logic              done,
  output logic              stale
);
  logic [WS_W-1:0] cnt;
  logic [WS_W-1:0] ws_q;

  // last cycle of the read: flash data is sampled here
  assign done = busy && (cnt == ws_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      ws_q    <= '0;
      rd_addr <= '0;
      kind    <= RK_IDLE;
      stale   <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= '0;
      ws_q    <= ws;
      rd_addr <= start_addr;
      kind    <= start_kind;
      stale   <= flush;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        kind <= RK_IDLE;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (flush) stale <= 1'b1;
    end
  end

  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(rd_addr)));
  p_read_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= ws_q));
endmodule

// File: rtl/pf_line_buf.sv
module pf_line_buf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              look_req,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam int TAG_W = ADDR_W - 2;

  logic             valid;
  logic [TAG_W-1:0] tag;
  logic [DATA_W-1:0] word;

  assign hit     = look_req && valid && (tag == look_addr[ADDR_W-1:2]);
  assign rd_data = word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      word  <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (wr_en) begin
      valid <= 1'b1;
      tag   <= wr_addr[ADDR_W-1:2];
      word  <= wr_data;
    end
  end

  p_fill_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> valid);
  // wr_addr low bits are unused by design; the address is word-aligned upstream
  p_wr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[1:0] == 2'b00));
endmodule

// File: rtl/flash_prefetcher.sv
module flash_prefetcher
  import pf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_en,
  input  logic [WS_W-1:0]   wait_states,
  input  logic              flush,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  output logic              flash_rd,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic [DATA_W-1:0] flash_rdata
);
  localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  function automatic logic [ADDR_W-1:0] word_base(input logic [ADDR_W-1:0] a);
    return a & ~LOW_MASK;
  endfunction

  function automatic logic [ADDR_W-1:0] next_word_addr(input logic [ADDR_W-1:0] a);
    return word_base(a) + WORD_STEP;
  endfunction

  function automatic logic same_word(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return word_base(a) == word_base(b);
  endfunction

  // named internal events
  logic              hit;
  logic [DATA_W-1:0] buf_data;
  logic              eng_busy, eng_done, eng_stale;
  logic [ADDR_W-1:0] eng_addr;
  rd_kind_e          eng_kind;
  logic              demand_start, spec_start, start;
  rd_kind_e          start_kind;
  logic [ADDR_W-1:0] spec_addr, start_addr;
  logic              fill_en, buf_clr;
  logic              pf_want;
  logic [ADDR_W-1:0] pf_addr;

  assign demand_start = fetch_req && !hit && !eng_busy;
  assign spec_start   = pf_en && !eng_busy && !flush && !demand_start && (hit || pf_want);
  assign spec_addr    = hit ? next_word_addr(fetch_addr) : pf_addr;
  assign start        = demand_start || spec_start;
  assign start_kind   = demand_start ? RK_DEMAND : RK_SPEC;
  assign start_addr   = demand_start ? word_base(fetch_addr) : spec_addr;

  // keep a finished read only if nobody is waiting for a different word
  assign fill_en = eng_done && !eng_stale && !flush &&
                   (!fetch_req || same_word(fetch_addr, eng_addr));
  // with prefetch off, a served word is not kept for reuse
  assign buf_clr = flush || (hit && !pf_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_want <= 1'b0;
      pf_addr <= '0;
    end else begin
      if (hit) pf_addr <= next_word_addr(fetch_addr);
      if (flush || !pf_en || start) pf_want <= 1'b0;
      else if (hit)                 pf_want <= 1'b1;
    end
  end

  pf_rd_engine #(.ADDR_W(ADDR_W), .WS_W(WS_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (start_kind),
    .start_addr (start_addr),
    .ws         (wait_states),
    .flush      (flush),
    .busy       (eng_busy),
    .rd_addr    (eng_addr),
    .kind       (eng_kind),
    .done       (eng_done),
    .stale      (eng_stale)
  );

  pf_line_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (fill_en),
    .wr_addr   (eng_addr),
    .wr_data   (flash_rdata),
    .clr       (buf_clr),
    .look_req  (fetch_req),
    .look_addr (fetch_addr),
    .hit       (hit),
    .rd_data   (buf_data)
  );

  assign fetch_ready = hit;
  assign fetch_data  = buf_data;
  assign flash_rd    = eng_busy;
  assign flash_addr  = eng_addr;

  p_ready_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> fetch_req);
  p_no_spec_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flash_rd) && !$past(pf_en)) |-> $past(fetch_req));
  p_spec_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_kind == RK_SPEC && $rose(flash_rd)) |-> $past(pf_en));
  p_pf_follows_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && pf_en && !flash_rd && !flush) |=>
      (flash_rd && flash_addr == next_word_addr($past(fetch_addr))));
  p_flush_blocks_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !fetch_ready);
endmodule

// File: tb/flash_prefetcher_test.sv
`timescale 1ns/1ps
module flash_prefetcher_test;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pf_en = 1'b0;
  logic [WW-1:0] wait_states = 4'd3;
  logic          flush = 1'b0;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_ready;
  logic [DW-1:0] fetch_data;
  logic          flash_rd;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_rdata;

  int n_checks = 0;
  int n_fail = 0;
  logic          after_rd;
  logic [AW-1:0] after_addr;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
    return {a, ~a, 8'h5A};
  endfunction

  assign flash_rdata = fdata(flash_addr);

  flash_prefetcher #(.ADDR_W(AW), .DATA_W(DW), .WS_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .pf_en(pf_en), .wait_states(wait_states),
    .flush(flush), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_rdata(flash_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // R2: length and address stability of every flash read
  int run_len = 0;
  logic [AW-1:0] run_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (flash_rd) begin
        if (run_len == 0) run_addr = flash_addr;
        else if (flash_addr != run_addr)
          check(1'b0, "R2", "flash_addr moved", flash_addr, run_addr);
        run_len++;
      end else if (run_len > 0) begin
        check(run_len == int'(wait_states) + 1, "R2", "read length", run_len, int'(wait_states) + 1);
        check(run_addr[1:0] == 2'b00, "R2", "read aligned", run_addr, run_addr & ~12'd3);
        run_len = 0;
      end
    end
  end

  // one fetch: returns edges from raise to ready, and the data
  task automatic fetch(input logic [AW-1:0] a, output int n, output logic [DW-1:0] d);
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_addr = a;
    n = 0;
    #0.5;
    while (!fetch_ready && n < 80) begin
      @(negedge clk);
      n++;
      #0.5;
    end
    d = fetch_data;
    @(posedge clk);
    #0.5;
    fetch_req = 1'b0;
    after_rd = flash_rd;
    after_addr = flash_addr;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #0.5;
      check(!fetch_ready, "R1", "fetch_ready after reset", fetch_ready, 0);
      check(!flash_rd, "R1", "flash_rd after reset", flash_rd, 0);
    end
  endtask

  task automatic t_disabled();
    int n; logic [DW-1:0] d;
    pf_en = 1'b0; wait_states = 4'd3;
    fetch(12'h102, n, d);  // low bits ignored
    check(n == 5, "R3", "miss latency ws=3", n, 5);
    check(d == fdata(12'h100), "R3", "miss data", d, fdata(12'h100));
    check(!after_rd, "R4", "no speculative read when off", after_rd, 0);
    idle(6);
    check(!flash_rd, "R4", "flash stays idle when off", flash_rd, 0);
    fetch(12'h100, n, d);
    check(n == 5, "R4", "repeat fetch pays full miss", n, 5);
    idle(2);
    wait_states = 4'd0;
    fetch(12'h200, n, d);
    check(n == 2, "R3", "miss latency ws=0", n, 2);
    check(d == fdata(12'h200), "R3", "miss data ws=0", d, fdata(12'h200));
    idle(3);
    wait_states = 4'd3;
  endtask

  task automatic t_sequential();
    int n; logic [DW-1:0] d;
    pf_en = 1'b1; pulse_flush();
    fetch(12'h300, n, d);
    check(n == 5, "R3", "first miss with prefetch on", n, 5);
    check(after_rd && after_addr == 12'h304, "R5", "prefetch of next word", after_addr, 12'h304);
    fetch(12'h304, n, d);
    check(n == 4, "R6", "back-to-back sequential", n, 4);
    check(d == fdata(12'h304), "R6", "prefetched data", d, fdata(12'h304));
    fetch(12'h308, n, d);
    check(n == 4, "R6", "second sequential", n, 4);
    idle(8);
  endtask

  task automatic t_late();
    int n; logic [DW-1:0] d;
    pulse_flush();
    fetch(12'h400, n, d);
    idle(6);
    fetch(12'h404, n, d);
    check(n == 0, "R7", "late sequential hit", n, 0);
    check(d == fdata(12'h404), "R7", "hit data", d, fdata(12'h404));
    idle(8);
  endtask

  task automatic t_mismatch();
    int n; logic [DW-1:0] d;
    pulse_flush();
    fetch(12'h500, n, d);
    fetch(12'h600, n, d);
    check(n == 9, "R8", "mismatch waits and rereads", n, 9);
    check(d == fdata(12'h600), "R8", "mismatch data", d, fdata(12'h600));
    idle(8);
  endtask

  task automatic t_flush();
    int n; logic [DW-1:0] d;
    pulse_flush();
    fetch(12'h700, n, d);
    idle(6);
    @(negedge clk); flush = 1'b1; #0.5;
    @(negedge clk); flush = 1'b0; #0.5;
    check(!fetch_ready, "R9", "no ready after flush", fetch_ready, 0);
    fetch(12'h704, n, d);
    check(n == 5, "R9", "flushed word is a miss", n, 5);
    idle(8);
  endtask

  task automatic t_wrap();
    int n; logic [DW-1:0] d;
    pulse_flush();
    fetch(12'hFFC, n, d);
    check(after_rd && after_addr == 12'h000, "R10", "prefetch wraps to 0", after_addr, 0);
    fetch(12'h000, n, d);
    check(n == 4, "R10", "wrapped hit latency", n, 4);
    check(d == fdata(12'h000), "R10", "wrapped data", d, fdata(12'h000));
    idle(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not end", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_sequential();
    t_late();
    t_mismatch();
    t_flush();
    t_wrap();
    finish_run();
  end
endmodule